// File: doc/BRIEF.md
# Xon/Xoff Software Flow Control Engine

This block sits between a UART receiver and its receive FIFO, next to the transmitter. Software sets a 4-bit mode field and four pause/resume characters: two resume codes, `resume_a` and `resume_b`, and two pause codes, `pause_a` and `pause_b`. Each received character is compared with the pause and resume patterns that the mode enables. In some modes a single character is enough for a match. In the sequence mode only an ordered pair matches. A matched pause raises `tx_halted`, which stops the transmitter after its current character. A matched resume clears it. Characters consumed by a match are not passed to the FIFO. All other characters are forwarded on a one-cycle write strobe.

On the transmit side, a rising FIFO-above-trigger level makes the block request pause characters. A rising FIFO-below-trigger level makes it request resume characters, but only if a pause was requested before. The block also flags every received byte that equals `pause_b` when special detection is on. That feature changes whether such a byte is stored, depending on the receive mode.

Top module: `swfc_engine`

## Requirements
- R1: With receive mode `mode[1:0]=00`, no character is consumed. Every received byte is written to the FIFO one cycle after its `rx_valid`, and `tx_halted` stays low. `tx_halted`, `fifo_wr`, `tx_req` and all flags are low after reset.
- R2: With `mode[1:0]=10`, a byte equal to `pause_a` is consumed, pulses `pause_det` and sets `tx_halted`. A byte equal to `resume_a` is consumed, pulses `resume_det` and clears `tx_halted`. `pause_b` and `resume_b` are forwarded.
- R3: With `mode[1:0]=01`, only `pause_b` and `resume_b` act as flow characters. `pause_a` and `resume_a` are forwarded.
- R4: With `mode[1:0]=11` and `mode[3:2]` equal to 10 or 01, either pause code halts and either resume code resumes, each as a single character.
- R5: With `mode[1:0]=11` and `mode[3:2]` equal to 11 or 00, a match needs the pair `pause_a` then `pause_b`, or the pair `resume_a` then `resume_b`. A lone first code is held back. If the next byte does not complete the pair, the held byte is written first and the new byte the cycle after. The new byte can itself open a new pair.
- R6: With `spec_en` set, each received byte equal to `pause_b` pulses `spec_det`. `spec_irq` pulses with it only when `spec_irq_en` is set. Under `mode[1:0]=10` such a byte is still written to the FIFO.
- R7: With `spec_en` set and `mode[1:0]=01`, a `pause_b` byte is not written. It pulses `pause_det` and `spec_det` in the same cycle.
- R8: On a rising `fifo_above_trigger`, the block issues `tx_req` pulses carrying the pause codes that `mode[3:2]` selects: 10 gives `pause_a`, 01 gives `pause_b`, and 11 gives `pause_a` then `pause_b` on consecutive cycles. With 00 it issues nothing.
- R9: A rising `fifo_below_trigger` issues the matching resume codes only if a pause request was issued since the last resume request. Otherwise it issues nothing.
- R10: Setting `mode[1:0]` to 00 clears `tx_halted`.
- R11: Received bytes are at least two clock cycles apart. FIFO writes keep arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 4 | [3:2] transmit set, [1:0] receive set |
| resume_a | input | DATA_W | First resume code |
| resume_b | input | DATA_W | Second resume code |
| pause_a | input | DATA_W | First pause code |
| pause_b | input | DATA_W | Second pause code, also the special pattern |
| spec_en | input | 1 | Enable special-character detection |
| spec_irq_en | input | 1 | Enable the special-character interrupt pulse |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | DATA_W | Received byte |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | DATA_W | Byte to write |
| pause_det | output | 1 | Pause matched (pulse) |
| resume_det | output | 1 | Resume matched (pulse) |
| spec_det | output | 1 | Special character seen (pulse) |
| spec_irq | output | 1 | Special-character interrupt (pulse) |
| tx_halted | output | 1 | Transmitter must pause |
| fifo_above_trigger | input | 1 | Receive FIFO level above upper trigger |
| fifo_below_trigger | input | 1 | Receive FIFO level below lower trigger |
| tx_req | output | 1 | Send-character request (pulse per character) |
| tx_char | output | DATA_W | Character to send |

## Verification
The bench builds the engine with `DATA_W` at its default of 8. It programs four distinct codes, so every overlap between single and paired matching can be told apart from the byte values alone. With 8-bit codes, the special pattern `pause_b` can also serve as a live flow character in the second receive set. That makes the consumed-versus-stored interplay of R6 and R7 observable at the FIFO port. Pair matching is driven through completed pairs, broken pairs and a broken pair whose breaking byte opens a new pair.

// File: rtl/swfc_pkg.sv
package swfc_pkg;

  typedef enum logic {
    KIND_RESUME = 1'b0,
    KIND_PAUSE  = 1'b1
  } fc_kind_e;

  typedef enum logic [2:0] {
    RXP_NONE   = 3'd0,
    RXP_SET_A  = 3'd1,
    RXP_SET_B  = 3'd2,
    RXP_EITHER = 3'd3,
    RXP_PAIR   = 3'd4
  } rx_plan_e;

  typedef enum logic [1:0] {
    TXP_NONE = 2'd0,
    TXP_A    = 2'd1,
    TXP_B    = 2'd2,
    TXP_PAIR = 2'd3
  } tx_plan_e;

  function automatic rx_plan_e decode_rx(input logic [3:0] m);
    rx_plan_e p;
    case (m[1:0])
      2'b10:   p = RXP_SET_A;
      2'b01:   p = RXP_SET_B;
      2'b11:   p = (m[3] ^ m[2]) ? RXP_EITHER : RXP_PAIR;
      default: p = RXP_NONE;
    endcase
    return p;
  endfunction

  function automatic tx_plan_e decode_tx(input logic [1:0] t);
    tx_plan_e p;
    case (t)
      2'b10:   p = TXP_A;
      2'b01:   p = TXP_B;
      2'b11:   p = TXP_PAIR;
      default: p = TXP_NONE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
  import swfc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rx_plan_e          plan,
  input  logic [DATA_W-1:0] resume_a,
  input  logic [DATA_W-1:0] resume_b,
  input  logic [DATA_W-1:0] pause_a,
  input  logic [DATA_W-1:0] pause_b,
  input  logic              spec_en,
  input  logic              spec_irq_en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data,
  output logic              pause_det,
  output logic              resume_det,
  output logic              spec_det,
  output logic              spec_irq
);

  logic              hold_vld_q, hold_vld_n;
  logic [DATA_W-1:0] hold_data_q, hold_data_n;
  fc_kind_e          hold_kind_q, hold_kind_n;
  logic              pend_vld_q, pend_vld_n;
  logic [DATA_W-1:0] pend_data_q, pend_data_n;
  logic              wr_q, wr_n;
  logic [DATA_W-1:0] wdata_q, wdata_n;
  logic              pdet_q, pdet_n, rdet_q, rdet_n;
  logic              sdet_q, sdet_n, sirq_q, sirq_n;

  logic is_ra, is_rb, is_pa, is_pb;
  logic hit_pause, hit_resume, open_pair, pair_done, flush, cur_wr;
  fc_kind_e open_kind;

  assign is_ra = (rx_data == resume_a);
  assign is_rb = (rx_data == resume_b);
  assign is_pa = (rx_data == pause_a);
  assign is_pb = (rx_data == pause_b);

  // classify the arriving byte
  always_comb begin
    hit_pause  = 1'b0;
    hit_resume = 1'b0;
    open_pair  = 1'b0;
    pair_done  = 1'b0;
    open_kind  = KIND_RESUME;
    case (plan)
      RXP_SET_A: begin
        hit_pause  = is_pa;
        hit_resume = is_ra & ~is_pa;
      end
      RXP_SET_B: begin
        hit_pause  = is_pb;
        hit_resume = is_rb & ~is_pb;
      end
      RXP_EITHER: begin
        hit_pause  = is_pa | is_pb;
        hit_resume = (is_ra | is_rb) & ~(is_pa | is_pb);
      end
      RXP_PAIR: begin
        if (hold_vld_q && hold_kind_q == KIND_PAUSE && is_pb) begin
          hit_pause = 1'b1;
          pair_done = 1'b1;
        end else if (hold_vld_q && hold_kind_q == KIND_RESUME && is_rb) begin
          hit_resume = 1'b1;
          pair_done  = 1'b1;
        end else if (is_pa) begin
          open_pair = 1'b1;
          open_kind = KIND_PAUSE;
        end else if (is_ra) begin
          open_pair = 1'b1;
          open_kind = KIND_RESUME;
        end
      end
      default: ;
    endcase
  end

  assign flush  = hold_vld_q & ~pair_done;
  assign cur_wr = ~(hit_pause | hit_resume | open_pair);

  // next state
  always_comb begin
    hold_vld_n  = hold_vld_q;
    hold_data_n = hold_data_q;
    hold_kind_n = hold_kind_q;
    pend_vld_n  = 1'b0;
    pend_data_n = pend_data_q;
    wr_n        = 1'b0;
    wdata_n     = wdata_q;
    pdet_n      = 1'b0;
    rdet_n      = 1'b0;
    sdet_n      = 1'b0;
    sirq_n      = 1'b0;
    if (rx_valid) begin
      hold_vld_n = open_pair;
      if (open_pair) begin
        hold_data_n = rx_data;
        hold_kind_n = open_kind;
      end
      if (flush) begin
        wr_n        = 1'b1;
        wdata_n     = hold_data_q;
        pend_vld_n  = cur_wr;
        pend_data_n = rx_data;
      end else if (cur_wr) begin
        wr_n    = 1'b1;
        wdata_n = rx_data;
      end
      pdet_n = hit_pause;
      rdet_n = hit_resume;
      sdet_n = spec_en & is_pb;
      sirq_n = spec_en & is_pb & spec_irq_en;
    end else if (pend_vld_q) begin
      wr_n    = 1'b1;
      wdata_n = pend_data_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q  <= 1'b0;
      hold_data_q <= '0;
      hold_kind_q <= KIND_RESUME;
      pend_vld_q  <= 1'b0;
      pend_data_q <= '0;
      wr_q        <= 1'b0;
      wdata_q     <= '0;
      pdet_q      <= 1'b0;
      rdet_q      <= 1'b0;
      sdet_q      <= 1'b0;
      sirq_q      <= 1'b0;
    end else begin
      hold_vld_q  <= hold_vld_n;
      hold_data_q <= hold_data_n;
      hold_kind_q <= hold_kind_n;
      pend_vld_q  <= pend_vld_n;
      pend_data_q <= pend_data_n;
      wr_q        <= wr_n;
      wdata_q     <= wdata_n;
      pdet_q      <= pdet_n;
      rdet_q      <= rdet_n;
      sdet_q      <= sdet_n;
      sirq_q      <= sirq_n;
    end
  end

  assign fifo_wr    = wr_q;
  assign fifo_data  = wdata_q;
  assign pause_det  = pdet_q;
  assign resume_det = rdet_q;
  assign spec_det   = sdet_q;
  assign spec_irq   = sirq_q;

endmodule

// File: rtl/swfc_tx_req.sv
module swfc_tx_req
  import swfc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tx_plan_e          plan,
  input  logic [DATA_W-1:0] resume_a,
  input  logic [DATA_W-1:0] resume_b,
  input  logic [DATA_W-1:0] pause_a,
  input  logic [DATA_W-1:0] pause_b,
  input  logic              above,
  input  logic              below,
  output logic              tx_req,
  output logic [DATA_W-1:0] tx_char
);

  typedef enum logic {ST_IDLE = 1'b0, ST_SECOND = 1'b1} st_e;

  st_e               st_q, st_n;
  logic              above_q, below_q;
  logic              sent_q, sent_n;
  logic [DATA_W-1:0] second_q, second_n;
  logic              req_q, req_n;
  logic [DATA_W-1:0] char_q, char_n;
  logic              rise_above, rise_below;

  assign rise_above = above & ~above_q;
  assign rise_below = below & ~below_q;

  always_comb begin
    st_n     = st_q;
    sent_n   = sent_q;
    second_n = second_q;
    req_n    = 1'b0;
    char_n   = char_q;
    if (st_q == ST_SECOND) begin
      req_n  = 1'b1;
      char_n = second_q;
      st_n   = ST_IDLE;
    end else if (rise_above && plan != TXP_NONE) begin
      req_n    = 1'b1;
      sent_n   = 1'b1;
      char_n   = (plan == TXP_B) ? pause_b : pause_a;
      second_n = pause_b;
      if (plan == TXP_PAIR) st_n = ST_SECOND;
    end else if (rise_below && sent_q && plan != TXP_NONE) begin
      req_n    = 1'b1;
      sent_n   = 1'b0;
      char_n   = (plan == TXP_B) ? resume_b : resume_a;
      second_n = resume_b;
      if (plan == TXP_PAIR) st_n = ST_SECOND;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      above_q  <= 1'b0;
      below_q  <= 1'b0;
      sent_q   <= 1'b0;
      second_q <= '0;
      req_q    <= 1'b0;
      char_q   <= '0;
    end else begin
      st_q     <= st_n;
      above_q  <= above;
      below_q  <= below;
      sent_q   <= sent_n;
      second_q <= second_n;
      req_q    <= req_n;
      char_q   <= char_n;
    end
  end

  assign tx_req  = req_q;
  assign tx_char = char_q;

endmodule

// File: rtl/swfc_engine.sv
module swfc_engine
  import swfc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode,
  input  logic [DATA_W-1:0] resume_a,
  input  logic [DATA_W-1:0] resume_b,
  input  logic [DATA_W-1:0] pause_a,
  input  logic [DATA_W-1:0] pause_b,
  input  logic              spec_en,
  input  logic              spec_irq_en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data,
  output logic              pause_det,
  output logic              resume_det,
  output logic              spec_det,
  output logic              spec_irq,
  output logic              tx_halted,
  input  logic              fifo_above_trigger,
  input  logic              fifo_below_trigger,
  output logic              tx_req,
  output logic [DATA_W-1:0] tx_char
);

  rx_plan_e rx_plan;
  tx_plan_e tx_plan;
  logic     halt_q, halt_n;

  assign rx_plan = decode_rx(mode);
  assign tx_plan = decode_tx(mode[3:2]);

  swfc_rx_match #(.DATA_W(DATA_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .plan        (rx_plan),
    .resume_a    (resume_a),
    .resume_b    (resume_b),
    .pause_a     (pause_a),
    .pause_b     (pause_b),
    .spec_en     (spec_en),
    .spec_irq_en (spec_irq_en),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .fifo_wr     (fifo_wr),
    .fifo_data   (fifo_data),
    .pause_det   (pause_det),
    .resume_det  (resume_det),
    .spec_det    (spec_det),
    .spec_irq    (spec_irq)
  );

  swfc_tx_req #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .plan     (tx_plan),
    .resume_a (resume_a),
    .resume_b (resume_b),
    .pause_a  (pause_a),
    .pause_b  (pause_b),
    .above    (fifo_above_trigger),
    .below    (fifo_below_trigger),
    .tx_req   (tx_req),
    .tx_char  (tx_char)
  );

  always_comb begin
    halt_n = halt_q;
    if (rx_plan == RXP_NONE) halt_n = 1'b0;
    else if (pause_det)      halt_n = 1'b1;
    else if (resume_det)     halt_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_n;
  end

  assign tx_halted = halt_q;

endmodule

// File: rtl/swfc_engine_chk.sv
module swfc_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode,
  input logic       pause_det,
  input logic       resume_det,
  input logic       spec_det,
  input logic       spec_irq,
  input logic       tx_halted,
  input logic       tx_req
);

  assert_halt_after_pause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_halted) |-> $past(pause_det));

  assert_release_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_halted) |-> ($past(resume_det) || $past(mode[1:0]) == 2'b00));

  assert_det_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pause_det && resume_det));

  assert_irq_needs_det_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spec_irq |-> spec_det);

  assert_no_tx_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !$past(tx_req)) |-> $past(mode[3:2]) != 2'b00);

  assert_pair_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !$past(tx_req) && $past(mode[3:2]) == 2'b11) |=> tx_req);

  assert_quiet_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode[1:0]) == 2'b00) |-> !(pause_det || resume_det));

endmodule

bind swfc_engine swfc_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .pause_det  (pause_det),
  .resume_det (resume_det),
  .spec_det   (spec_det),
  .spec_irq   (spec_irq),
  .tx_halted  (tx_halted),
  .tx_req     (tx_req)
);

// File: tb/swfc_engine_tb.sv
module swfc_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam logic [DW-1:0] RA = 8'h11, RB = 8'h91, PA = 8'h13, PB = 8'h93;

  logic clk, rst_n;
  logic [3:0] mode;
  logic spec_en, spec_irq_en, rx_valid, above, below;
  logic [DW-1:0] rx_data;
  logic fifo_wr, pause_det, resume_det, spec_det, spec_irq, tx_halted, tx_req;
  logic [DW-1:0] fifo_data, tx_char;

  int checks = 0, fails = 0, cyc = 0;
  logic [DW-1:0] wr_log [64];
  logic [DW-1:0] tx_log [64];
  int tx_cyc [64];
  int wr_n = 0, tx_n = 0, pd_n = 0, rd_n = 0, sd_n = 0, si_n = 0, both_n = 0;

  swfc_engine #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .resume_a(RA), .resume_b(RB), .pause_a(PA), .pause_b(PB),
    .spec_en(spec_en), .spec_irq_en(spec_irq_en),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .pause_det(pause_det), .resume_det(resume_det),
    .spec_det(spec_det), .spec_irq(spec_irq), .tx_halted(tx_halted),
    .fifo_above_trigger(above), .fifo_below_trigger(below),
    .tx_req(tx_req), .tx_char(tx_char)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    cyc++;
    if (fifo_wr && wr_n < 64) begin wr_log[wr_n] = fifo_data; wr_n++; end
    if (tx_req && tx_n < 64) begin tx_log[tx_n] = tx_char; tx_cyc[tx_n] = cyc; tx_n++; end
    if (pause_det) pd_n++;
    if (resume_det) rd_n++;
    if (spec_det) sd_n++;
    if (spec_irq) si_n++;
    if (pause_det && spec_det) both_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    @(negedge clk);
    wr_n = 0; tx_n = 0; pd_n = 0; rd_n = 0; sd_n = 0; si_n = 0; both_n = 0;
  endtask

  task automatic rx_byte(input logic [DW-1:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!tx_halted && !fifo_wr && !tx_req && !pause_det && !spec_det, "R1 reset", 
        {tx_halted, fifo_wr, tx_req, pause_det, spec_det}, 0);
  endtask

  task automatic t_off_r1();
    mode = 4'b0000; clr();
    rx_byte(PA); rx_byte(RA);
    chk(wr_n == 2 && wr_log[0] == PA && wr_log[1] == RA, "R1 forward", wr_n, 2);
    chk(!tx_halted && pd_n == 0, "R1 no halt", tx_halted, 0);
  endtask

  task automatic t_set_a_r2();
    mode = 4'b0010; clr();
    rx_byte(PA);
    chk(tx_halted && pd_n == 1 && wr_n == 0, "R2 pause_a halts", wr_n, 0);
    rx_byte(PB); rx_byte(RB);
    chk(wr_n == 2 && wr_log[0] == PB && wr_log[1] == RB && tx_halted, "R2 set b forwarded", wr_n, 2);
    rx_byte(RA);
    chk(!tx_halted && rd_n == 1 && wr_n == 2, "R2 resume_a", tx_halted, 0);
  endtask

  task automatic t_set_b_r3();
    mode = 4'b0001; clr();
    rx_byte(PA);
    chk(!tx_halted && wr_n == 1 && wr_log[0] == PA, "R3 pause_a forwarded", wr_n, 1);
    rx_byte(PB);
    chk(tx_halted && wr_n == 1, "R3 pause_b halts", tx_halted, 1);
    rx_byte(RB);
    chk(!tx_halted && wr_n == 1, "R3 resume_b", tx_halted, 0);
  endtask

  task automatic t_either_r4();
    mode = 4'b1011; clr();
    rx_byte(PB);
    chk(tx_halted, "R4 pause_b alone", tx_halted, 1);
    rx_byte(RA);
    chk(!tx_halted, "R4 resume_a alone", tx_halted, 0);
    mode = 4'b0111;
    rx_byte(PA);
    chk(tx_halted && wr_n == 0, "R4 pause_a alone", wr_n, 0);
    rx_byte(RB);
    chk(!tx_halted && wr_n == 0, "R4 resume_b alone", tx_halted, 0);
  endtask

  task automatic t_pair_r5();
    mode = 4'b1111; clr();
    rx_byte(PA);
    chk(!tx_halted && wr_n == 0, "R5 first held", wr_n, 0);
    rx_byte(PB);
    chk(tx_halted && wr_n == 0 && pd_n == 1, "R5 pause pair", tx_halted, 1);
    rx_byte(RA); rx_byte(8'h41);
    chk(wr_n == 2 && wr_log[0] == RA && wr_log[1] == 8'h41 && tx_halted, "R5 R11 broken pair order",
        {wr_log[0], wr_log[1]}, {RA, 8'h41});
    clr();
    rx_byte(RA); rx_byte(RA); rx_byte(RB);
    chk(wr_n == 1 && wr_log[0] == RA && !tx_halted, "R5 rebuilt pair", wr_n, 1);
    mode = 4'b0011; clr();
    rx_byte(PB);
    chk(wr_n == 1 && !tx_halted, "R5 lone second in pair mode", wr_n, 1);
  endtask

  task automatic t_spec_r6();
    mode = 4'b0010; spec_en = 1'b1; spec_irq_en = 1'b0; clr();
    rx_byte(PB);
    chk(wr_n == 1 && wr_log[0] == PB && sd_n == 1 && si_n == 0, "R6 special stored no irq", si_n, 0);
    spec_irq_en = 1'b1;
    rx_byte(PB);
    chk(wr_n == 2 && sd_n == 2 && si_n == 1 && !tx_halted, "R6 special irq", si_n, 1);
    rx_byte(8'h55);
    chk(sd_n == 2, "R6 other byte not special", sd_n, 2);
  endtask

  task automatic t_spec_r7();
    mode = 4'b0001; spec_en = 1'b1; spec_irq_en = 1'b1; clr();
    rx_byte(PB);
    chk(wr_n == 0 && both_n == 1 && si_n == 1 && tx_halted, "R7 special consumed", wr_n, 0);
    spec_en = 1'b0;
  endtask

  task automatic t_off_clears_r10();
    mode = 4'b0010; clr();
    rx_byte(PA);
    chk(tx_halted, "R10 halted first", tx_halted, 1);
    mode = 4'b0000;
    repeat (2) @(negedge clk);
    chk(!tx_halted, "R10 mode off clears", tx_halted, 0);
  endtask

  task automatic pulse_level(input bit up);
    @(negedge clk); if (up) above = 1'b1; else below = 1'b1;
    repeat (4) @(negedge clk);
    if (up) above = 1'b0; else below = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_tx_r8_r9();
    mode = 4'b1000; clr();
    pulse_level(1'b0);
    chk(tx_n == 0, "R9 resume without pause", tx_n, 0);
    pulse_level(1'b1);
    chk(tx_n == 1 && tx_log[0] == PA, "R8 pause_a sent", tx_n, 1);
    pulse_level(1'b0);
    chk(tx_n == 2 && tx_log[1] == RA, "R9 resume_a sent", tx_n, 2);
    mode = 4'b0100; clr();
    pulse_level(1'b1); pulse_level(1'b0);
    chk(tx_n == 2 && tx_log[0] == PB && tx_log[1] == RB, "R8 R9 set b", tx_n, 2);
    mode = 4'b1100; clr();
    pulse_level(1'b1);
    chk(tx_n == 2 && tx_log[0] == PA && tx_log[1] == PB && tx_cyc[1] == tx_cyc[0] + 1,
        "R8 pause pair", tx_n, 2);
    pulse_level(1'b0);
    chk(tx_n == 4 && tx_log[2] == RA && tx_log[3] == RB, "R9 resume pair", tx_n, 4);
    mode = 4'b0000; clr();
    pulse_level(1'b1);
    chk(tx_n == 0, "R8 mode off silent", tx_n, 0);
  endtask

  initial begin
    int limit;
    limit = 20000;
    while (limit > 0 && fails >= 0) begin
      @(posedge clk); limit--;
    end
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 4'b0000; spec_en = 1'b0; spec_irq_en = 1'b0;
    rx_valid = 1'b0; rx_data = '0; above = 1'b0; below = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_off_r1();
    t_set_a_r2();
    t_set_b_r3();
    t_either_r4();
    t_pair_r5();
    t_spec_r6();
    t_spec_r7();
    t_off_clears_r10();
    t_tx_r8_r9();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule